// File: doc/BRIEF.md
# Priority Interrupt Recognition Controller

This block sits beside a small 16-bit processor core and decides, at each instruction boundary, whether the core takes an interrupt and which memory location it fetches the interrupt instruction from. Two request lines have hard-wired locations. The core supplies an end-of-instruction strobe, the machine's run and stop status, and pulses from the instructions that turn the global interrupt enable on and off. A third, vectored request line carries a location address that the requesting peripheral drives.

When an interrupt is taken, the block pulses a take signal together with a one-hot acknowledge that names the winning source. It presents the location address. It then holds an interrupt-cycle flag until the core finishes the one instruction at that location, and the core uses this flag to keep its program counter from advancing. If that interrupt instruction turns out to be a jump-and-store, the core reports it and the global enable drops. After an enable instruction, the block always lets one further instruction run before it recognizes anything.

Top module: `irq_recog_ctl`

## Requirements
- R1: Fixed request line i has location LOC_BASE + LOC_STRIDE*i. With the defaults, line 0 maps to 0x0002 and line 1 maps to 0x0006. A lower index has higher priority.
- R2: When the vectored line wins, int_loc equals the vec_addr value present at the clock edge where the interrupt was taken.
- R3: Recognition happens only at a rising clock edge where instr_done is 1. take_int is then 1 for exactly the following cycle.
- R4: An interrupt is taken only if the global enable is set, run_mode is 1 and stop_sw is 0. The global enable is cleared at reset.
- R5: Priority is fixed line 0 first, then the remaining fixed lines in index order, then the vectored line. ack_fix and ack_vec form a one-hot code that is active only in the take_int cycle and names the source taken.
- R6: A rising edge on a fixed line makes that line pending until it is acknowledged, even if the line has since dropped. The vectored line is level-sensitive and is forgotten if it drops before a boundary.
- R7: en_set is pulsed together with instr_done of the enable instruction. That boundary, and the next GRACE boundaries after it (default 1), take no interrupt.
- R8: int_cycle rises with take_int. It stays high until the next boundary, unless that boundary takes another interrupt.
- R9: jst_exec with instr_done while int_cycle is high clears the global enable. No interrupt is taken at that boundary or at any later one until en_set is given again.
- R10: en_clr clears the global enable at once. No interrupt is taken at a boundary in the same cycle.
- R11: After reset, take_int, int_cycle, int_loc and all acknowledges are 0, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fix_req | input | N_FIX | Fixed-location request lines, bit 0 highest priority |
| vec_req | input | 1 | Vectored request, level-sensitive |
| vec_addr | input | AW | Location supplied with the vectored request |
| en_set | input | 1 | Enable instruction completing (given with instr_done) |
| en_clr | input | 1 | Disable instruction, immediate |
| run_mode | input | 1 | Core is running (not halted) |
| stop_sw | input | 1 | Stop switch asserted |
| instr_done | input | 1 | End-of-instruction strobe |
| jst_exec | input | 1 | Completing instruction is a jump-and-store |
| take_int | output | 1 | One-cycle pulse: interrupt taken |
| int_loc | output | AW | Interrupt location address |
| int_cycle | output | 1 | Core is executing the interrupt instruction |
| ack_fix | output | N_FIX | One-hot acknowledge of a fixed line |
| ack_vec | output | 1 | Acknowledge of the vectored line |

## Verification
A pending flag that is stuck or lost shows up at the next boundary: an interrupt is taken that should not be, an expected one is missing, or the location and acknowledge name the wrong source. A grace counter or enable bit in the wrong state changes whether take_int pulses one cycle after a boundary, so the error shows within a single instruction. A reference model in the bench tracks pending, enable, grace and interrupt-cycle state from the inputs alone. Every output is compared with it in every cycle, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/irq_recog_pkg.sv
package irq_recog_pkg;

   // Location assigned to fixed request line idx.
   function automatic int unsigned fix_loc(input int unsigned idx,
                                           input int unsigned base,
                                           input int unsigned stride);
      return base + stride * idx;
   endfunction

   // Width of a down-counter able to hold n.
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/irq_pend_cell.sv
module irq_pend_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic ack,
   output logic pend
);
   logic prev_q;
   logic pend_q;
   logic rise;

   assign rise = req & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= req;
         // a fresh edge wins over an acknowledge in the same cycle
         pend_q <= (pend_q & ~ack) | rise;
      end
   end

   assign pend = pend_q;
endmodule

// File: rtl/irq_en_gate.sv
module irq_en_gate #(
   parameter int unsigned GRACE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_set,
   input  logic en_clr,
   input  logic jst_clr,
   input  logic instr_done,
   output logic en_eff,
   output logic blocked
);
   import irq_recog_pkg::*;

   localparam int unsigned GW = cnt_width(GRACE);

   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= 1'b0;
      else if (en_clr)  en_q <= 1'b0;
      else if (jst_clr) en_q <= 1'b0;
      else if (en_set)  en_q <= 1'b1;
   end

   // enable as seen by the boundary being evaluated this cycle
   assign en_eff = en_q & ~en_clr & ~jst_clr;

   generate
      if (GRACE == 0) begin : g_no_grace
         assign blocked = en_set;
      end else begin : g_grace
         logic [GW-1:0] grace_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               grace_q <= '0;
            else if (en_set)
               grace_q <= GW'(GRACE);
            else if (instr_done && (grace_q != '0))
               grace_q <= grace_q - 1'b1;
         end
         assign blocked = en_set | (grace_q != '0);
      end
   endgenerate
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
   parameter int unsigned N_FIX      = 2,
   parameter int unsigned AW         = 16,
   parameter int unsigned LOC_BASE   = 2,
   parameter int unsigned LOC_STRIDE = 4
) (
   input  logic [N_FIX-1:0] pend,
   input  logic             vec_req,
   input  logic [AW-1:0]    vec_addr,
   output logic             any,
   output logic [N_FIX-1:0] sel_fix,
   output logic             sel_vec,
   output logic [AW-1:0]    loc
);
   import irq_recog_pkg::*;

   logic [N_FIX-1:0] above;
   logic             any_fix;

   generate
      for (genvar i = 0; i < N_FIX; i++) begin : g_chain
         if (i == 0) begin : g_top
            assign above[i] = 1'b0;
         end else begin : g_rest
            assign above[i] = above[i-1] | pend[i-1];
         end
         assign sel_fix[i] = pend[i] & ~above[i];
      end
   endgenerate

   assign any_fix = |pend;
   assign sel_vec = vec_req & ~any_fix;
   assign any     = any_fix | vec_req;

   always_comb begin
      loc = vec_addr;
      for (int i = N_FIX - 1; i >= 0; i--) begin
         if (pend[i]) loc = AW'(fix_loc(i, LOC_BASE, LOC_STRIDE));
      end
   end
endmodule

// File: rtl/irq_recog_ctl.sv
module irq_recog_ctl #(
   parameter int unsigned N_FIX      = 2,
   parameter int unsigned AW         = 16,
   parameter int unsigned LOC_BASE   = 2,
   parameter int unsigned LOC_STRIDE = 4,
   parameter int unsigned GRACE      = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_FIX-1:0] fix_req,
   input  logic             vec_req,
   input  logic [AW-1:0]    vec_addr,
   input  logic             en_set,
   input  logic             en_clr,
   input  logic             run_mode,
   input  logic             stop_sw,
   input  logic             instr_done,
   input  logic             jst_exec,
   output logic             take_int,
   output logic [AW-1:0]    int_loc,
   output logic             int_cycle,
   output logic [N_FIX-1:0] ack_fix,
   output logic             ack_vec
);
   import irq_recog_pkg::*;

   localparam longint unsigned LAST_LOC =
      longint'(LOC_BASE) + longint'(LOC_STRIDE) * longint'(N_FIX - 1);

   generate
      if (N_FIX < 1) begin : g_bad_nfix
         $error("N_FIX must be at least 1");
      end
      if (AW < 2 || AW > 32) begin : g_bad_aw
         $error("AW out of range");
      end
      if (LAST_LOC >= (64'd1 << AW)) begin : g_bad_loc
         $error("fixed locations do not fit in AW bits");
      end
   endgenerate

   logic [N_FIX-1:0] pend;
   logic [N_FIX-1:0] sel_fix;
   logic             sel_vec;
   logic             any_req;
   logic [AW-1:0]    sel_loc;
   logic             en_eff;
   logic             blocked;
   logic             jst_clr;
   logic             go;

   logic             take_q;
   logic [AW-1:0]    loc_q;
   logic             icyc_q;
   logic [N_FIX-1:0] ackf_q;
   logic             ackv_q;

   assign jst_clr = icyc_q & instr_done & jst_exec;

   generate
      for (genvar i = 0; i < N_FIX; i++) begin : g_pend
         irq_pend_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (fix_req[i]),
            .ack  (go & sel_fix[i]),
            .pend (pend[i])
         );
      end
   endgenerate

   irq_prio_sel #(
      .N_FIX     (N_FIX),
      .AW        (AW),
      .LOC_BASE  (LOC_BASE),
      .LOC_STRIDE(LOC_STRIDE)
   ) u_sel (
      .pend    (pend),
      .vec_req (vec_req),
      .vec_addr(vec_addr),
      .any     (any_req),
      .sel_fix (sel_fix),
      .sel_vec (sel_vec),
      .loc     (sel_loc)
   );

   irq_en_gate #(
      .GRACE(GRACE)
   ) u_en (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_set    (en_set),
      .en_clr    (en_clr),
      .jst_clr   (jst_clr),
      .instr_done(instr_done),
      .en_eff    (en_eff),
      .blocked   (blocked)
   );

   assign go = instr_done & en_eff & ~blocked & run_mode & ~stop_sw & any_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_q <= 1'b0;
         loc_q  <= '0;
         icyc_q <= 1'b0;
         ackf_q <= '0;
         ackv_q <= 1'b0;
      end else begin
         take_q <= go;
         ackf_q <= go ? sel_fix : '0;
         ackv_q <= go & sel_vec;
         if (go)              loc_q <= sel_loc;
         if (go)              icyc_q <= 1'b1;
         else if (instr_done) icyc_q <= 1'b0;
      end
   end

   assign take_int  = take_q;
   assign int_loc   = loc_q;
   assign int_cycle = icyc_q;
   assign ack_fix   = ackf_q;
   assign ack_vec   = ackv_q;
endmodule

// File: rtl/irq_recog_chk.sv
module irq_recog_chk #(
   parameter int unsigned N_FIX      = 2,
   parameter int unsigned AW         = 16,
   parameter int unsigned LOC_BASE   = 2,
   parameter int unsigned LOC_STRIDE = 4,
   parameter int unsigned GRACE      = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_FIX-1:0] fix_req,
   input logic             vec_req,
   input logic [AW-1:0]    vec_addr,
   input logic             en_set,
   input logic             en_clr,
   input logic             run_mode,
   input logic             stop_sw,
   input logic             instr_done,
   input logic             jst_exec,
   input logic             take_int,
   input logic [AW-1:0]    int_loc,
   input logic             int_cycle,
   input logic [N_FIX-1:0] ack_fix,
   input logic             ack_vec
);
   import irq_recog_pkg::*;

   // boundaries seen since the last enable, saturating at GRACE
   int unsigned gcnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          gcnt_q <= GRACE;
      else if (en_set)                     gcnt_q <= 0;
      else if (instr_done && gcnt_q < GRACE) gcnt_q <= gcnt_q + 1;
   end

   generate
      for (genvar i = 0; i < N_FIX; i++) begin : g_loc
         a_r1_fixed_loc: assert property (@(posedge clk) disable iff (!rst_n)
            ack_fix[i] |-> (int_loc == AW'(fix_loc(i, LOC_BASE, LOC_STRIDE))));
      end
   endgenerate

   a_r2_vec_loc: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vec |-> (int_loc == $past(vec_addr)));

   a_r3_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |-> $past(instr_done));

   a_r3_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |=> (!take_int || $past(instr_done)));

   a_r4_run: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |-> $past(run_mode && !stop_sw));

   a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |-> ($countones({ack_fix, ack_vec}) == 1));

   a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !take_int |-> ({ack_fix, ack_vec} == '0));

   a_r6_vec_level: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vec |-> $past(vec_req));

   a_r7_grace: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |-> $past(gcnt_q >= GRACE && !en_set));

   a_r8_icyc: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |-> int_cycle);

   a_r9_jst: assert property (@(posedge clk) disable iff (!rst_n)
      (int_cycle && instr_done && jst_exec) |=> !take_int);

   a_r10_clr: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr |=> !take_int);
endmodule

bind irq_recog_ctl irq_recog_chk #(
   .N_FIX(N_FIX), .AW(AW), .LOC_BASE(LOC_BASE),
   .LOC_STRIDE(LOC_STRIDE), .GRACE(GRACE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fix_req(fix_req), .vec_req(vec_req),
   .vec_addr(vec_addr), .en_set(en_set), .en_clr(en_clr),
   .run_mode(run_mode), .stop_sw(stop_sw), .instr_done(instr_done),
   .jst_exec(jst_exec), .take_int(take_int), .int_loc(int_loc),
   .int_cycle(int_cycle), .ack_fix(ack_fix), .ack_vec(ack_vec)
);

// File: tb/irq_recog_ctl_tb.sv
module irq_recog_ctl_tb;
   localparam int unsigned NF = 2;
   localparam int unsigned AW = 16;
   localparam int unsigned GR = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [NF-1:0] b_req = '0;
   logic          b_vreq = 1'b0;
   logic [AW-1:0] b_vaddr = '0;
   logic          b_set = 1'b0, b_clr = 1'b0, b_run = 1'b1, b_stop = 1'b0;
   logic          b_done = 1'b0, b_jst = 1'b0;

   logic          take_int, int_cycle, ack_vec;
   logic [AW-1:0] int_loc;
   logic [NF-1:0] ack_fix;

   irq_recog_ctl #(.N_FIX(NF), .AW(AW), .GRACE(GR)) u_dut (
      .clk(clk), .rst_n(rst_n), .fix_req(b_req), .vec_req(b_vreq),
      .vec_addr(b_vaddr), .en_set(b_set), .en_clr(b_clr),
      .run_mode(b_run), .stop_sw(b_stop), .instr_done(b_done),
      .jst_exec(b_jst), .take_int(take_int), .int_loc(int_loc),
      .int_cycle(int_cycle), .ack_fix(ack_fix), .ack_vec(ack_vec)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   // reference model state
   logic          m_en, m_take, m_icyc, m_ackv;
   int            m_grace;
   logic [NF-1:0] m_pend, m_prev, m_ackf;
   logic [AW-1:0] m_loc;

   function automatic logic [AW-1:0] loc_of(input int idx);
      return AW'(2 + 4 * idx);
   endfunction

   task automatic ck(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_en = 0; m_take = 0; m_icyc = 0; m_ackv = 0; m_grace = 0;
      m_pend = '0; m_prev = '0; m_ackf = '0; m_loc = '0;
   endtask

   task automatic model_next();
      logic [NF-1:0] rise, sel;
      logic jclr, en_eff, blk, go, anyf;
      rise   = b_req & ~m_prev;
      jclr   = m_icyc & b_done & b_jst;
      en_eff = m_en & ~b_clr & ~jclr;
      blk    = b_set | (m_grace != 0);
      anyf   = |m_pend;
      go     = b_done & en_eff & ~blk & b_run & ~b_stop & (anyf | b_vreq);
      sel    = '0;
      for (int i = 0; i < NF; i++) if (m_pend[i] && sel == '0) sel[i] = 1'b1;
      m_take = go;
      m_ackf = go ? sel : '0;
      m_ackv = go & ~anyf & b_vreq;
      if (go) begin
         m_loc = b_vaddr;
         for (int i = 0; i < NF; i++) if (sel[i]) m_loc = loc_of(i);
      end
      if (go) m_icyc = 1;
      else if (b_done) m_icyc = 0;
      m_pend = (m_pend & ~(go ? sel : '0)) | rise;
      m_prev = b_req;
      if (b_clr) m_en = 0;
      else if (jclr) m_en = 0;
      else if (b_set) m_en = 1;
      if (b_set) m_grace = GR;
      else if (b_done && m_grace != 0) m_grace = m_grace - 1;
   endtask

   // called at a falling edge; advances one clock and compares at the next falling edge
   task automatic step();
      model_next();
      @(negedge clk);
      ck(take_int === m_take, "R3 take_int", take_int, m_take);
      ck(int_loc === m_loc, "R1 int_loc", int_loc, m_loc);
      ck(ack_fix === m_ackf && ack_vec === m_ackv, "R5 ack",
         {ack_fix, ack_vec}, {m_ackf, m_ackv});
      ck(int_cycle === m_icyc, "R8 int_cycle", int_cycle, m_icyc);
      b_set = 0; b_clr = 0; b_done = 0; b_jst = 0;
   endtask

   task automatic bnd();
      b_done = 1;
      step();
   endtask

   task automatic pulse_req(input logic [NF-1:0] m);
      b_req = m; step();
      b_req = '0; step();
   endtask

   task automatic enable_now();
      b_set = 1; b_done = 1; step();
      ck(take_int == 0, "R7 enable boundary", take_int, 0);
      bnd();
      ck(take_int == 0, "R7 grace boundary", take_int, 0);
   endtask

   initial begin
      void'($urandom(32'h5eed_1a2b));
      model_reset();
      repeat (3) @(negedge clk);
      ck(take_int == 0 && int_cycle == 0 && int_loc == 0 &&
         ack_fix == 0 && ack_vec == 0, "R11 reset outputs",
         {take_int, int_cycle, ack_fix, ack_vec}, 0);
      rst_n = 1;
      @(negedge clk);

      // R1/R7/R8: line 1 waits out the grace window
      b_req = 2'b10; step();
      enable_now();
      bnd();
      ck(take_int == 1 && int_loc == 16'h0006, "R1 line1 loc", int_loc, 16'h0006);
      ck(int_cycle == 1, "R8 set with take", int_cycle, 1);
      step();
      ck(take_int == 0 && int_cycle == 1, "R3 single pulse / R8 held",
         {take_int, int_cycle}, 2'b01);
      bnd();
      ck(int_cycle == 0, "R8 ends at boundary", int_cycle, 0);

      // R5: all three at once, served by priority
      b_req = '0; step();
      b_req = 2'b11; b_vreq = 1; b_vaddr = 16'h1234; step();
      bnd();
      ck(ack_fix == 2'b01 && int_loc == 16'h0002, "R5 line0 first", int_loc, 16'h0002);
      bnd();
      ck(ack_fix == 2'b10 && int_loc == 16'h0006, "R5 line1 second", int_loc, 16'h0006);
      bnd();
      ck(ack_vec == 1 && int_loc == 16'h1234, "R2 vector loc", int_loc, 16'h1234);
      b_vaddr = 16'hBEEF; bnd();
      ck(ack_vec == 1 && int_loc == 16'hBEEF, "R2 vector resampled", int_loc, 16'hBEEF);
      b_vreq = 0; bnd();
      b_req = '0; step();

      // R6: dropped vector is forgotten, dropped fixed line is kept
      b_vreq = 1; step(); b_vreq = 0; step();
      bnd();
      ck(take_int == 0, "R6 vector not held", take_int, 0);
      pulse_req(2'b01);
      bnd();
      ck(take_int == 1 && int_loc == 16'h0002, "R6 fixed held", int_loc, 16'h0002);
      bnd();

      // R4: halted and stop switch block recognition
      pulse_req(2'b01);
      b_run = 0; bnd();
      ck(take_int == 0, "R4 halted", take_int, 0);
      b_run = 1; b_stop = 1; bnd();
      ck(take_int == 0, "R4 stop switch", take_int, 0);
      b_stop = 0; bnd();
      ck(take_int == 1, "R4 running again", take_int, 1);
      bnd();

      // R9: jump-and-store as interrupt instruction drops enable
      pulse_req(2'b11);
      bnd();
      ck(int_loc == 16'h0002, "R9 setup take", int_loc, 16'h0002);
      b_jst = 1; bnd();
      ck(take_int == 0, "R9 jst boundary", take_int, 0);
      bnd();
      ck(take_int == 0, "R9 stays disabled", take_int, 0);
      enable_now();
      bnd();
      ck(take_int == 1 && int_loc == 16'h0006, "R9 pending survives", int_loc, 16'h0006);
      bnd();

      // R10: immediate disable
      pulse_req(2'b01);
      b_clr = 1; bnd();
      ck(take_int == 0, "R10 clr same boundary", take_int, 0);
      bnd();
      ck(take_int == 0, "R10 stays off", take_int, 0);
      enable_now();
      bnd();
      ck(take_int == 1 && int_loc == 16'h0002, "R10 pending kept", int_loc, 16'h0002);
      bnd();

      // random phase against the model
      for (int k = 0; k < 4000; k++) begin
         b_done  = ($urandom % 3) == 0;
         b_set   = b_done && (($urandom % 12) == 0);
         b_clr   = ($urandom % 50) == 0;
         b_jst   = b_done && !b_set && (($urandom % 4) == 0);
         b_run   = ($urandom % 16) != 0;
         b_stop  = ($urandom % 16) == 0;
         if (($urandom % 4) == 0) b_req = NF'($urandom);
         if (($urandom % 5) == 0) b_vreq = ~b_vreq;
         b_vaddr = AW'($urandom);
         step();
      end

      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule